// File: doc/BRIEF.md
# Link Change Interrupt Controller

This block tells a host that the link state of a port has changed. Every change of the link status input, whether the link goes up or down, raises an interrupt. The interrupt stays raised until the host acknowledges it with a single-cycle register-write strobe. Further link changes that arrive while the interrupt is raised are folded into one pending event. When the host acknowledges, that pending event drops the interrupt for a short, fixed gap and then raises it again. The host therefore sees a fresh edge for the change it has not yet serviced.

The interrupt shares output pins with status LED indications. A configuration input selects where it goes. In one setting it takes over the collision pin, and activity keeps its own pin. In the other it takes over the activity pin, and activity is then shown by blinking the link LED. A control bit selects the interrupt polarity. Activity pulses are stretched, and the blink rate is divided down, so that both can be seen by eye.

The link status, activity pulses and collision input are expected to be synchronous to the clock. The reset is asserted asynchronously and released synchronously inside the block.

Top module: `link_irq_ctrl`

## Requirements
- R1: A change of `link_up` in either direction, seen while no interrupt is raised and no gap is running, raises the interrupt at the next clock edge.
- R2: A raised interrupt stays raised until a one-cycle `ack_wr` strobe is seen. If no event is pending, that strobe lowers it at the next edge. An `ack_wr` while no interrupt is raised has no effect.
- R3: If at least one link change arrived while the interrupt was raised, an acknowledge lowers the interrupt for exactly GAP_CYCLES clock cycles and then raises it again. The default is 3 cycles, which is 120 ns at 25 MHz.
- R4: Only one event can be pending. Any number of changes before an acknowledge, plus any changes during the gap, give exactly one reassertion, and the next acknowledge lowers the interrupt for good.
- R5: With `irq_invert` = 0 the interrupt level is active low (0 = raised). With `irq_invert` = 1 it is active high.
- R6: With `pin_cfg` = 1, `pin_col_n` carries the interrupt level and `pin_act_n` carries the activity LED (active low). `link_led_n` is 0 while the link is up and 1 while it is down.
- R7: With `pin_cfg` = 0, `pin_act_n` carries the interrupt level and `pin_col_n` is the inverse of `coll`.
- R8: With `pin_cfg` = 0, `link_led_n` is 1 with no link and 0 with link and no activity. With link and activity it is 0 for the first BLINK_DIV cycles after activity starts, then inverts every BLINK_DIV cycles.
- R9: An `act_pulse` keeps the activity indication on from the next edge for ACT_HOLD cycles. A new pulse restarts that window.
- R10: After reset the link is taken as down, no interrupt is raised, and every pin sits at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Current link status, 1 = link up |
| act_pulse | input | 1 | One-cycle pulse per transmit or receive activity |
| coll | input | 1 | Collision indication, active high |
| ack_wr | input | 1 | One-cycle strobe from a write to the acknowledge register |
| irq_invert | input | 1 | Interrupt polarity select, 1 = active high |
| pin_cfg | input | 1 | Pin routing select |
| pin_act_n | output | 1 | Activity LED or interrupt, by pin_cfg |
| pin_col_n | output | 1 | Interrupt or collision LED, by pin_cfg |
| link_led_n | output | 1 | Link LED, blinking on activity when pin_cfg = 0 |

## Verification
The interrupt path is driven with several link patterns:
- A single change with no pending event. Its acknowledge must end the interrupt cleanly.
- A burst of three changes before acknowledge. This separates one queued event from several.
- A change that lands inside the deassertion gap. It must merge into the reassertion rather than queue a second event.

A stray acknowledge while no interrupt is raised shows whether the strobe is ignored when idle. A table sweeps routing mode, polarity and collision with the link down, which separates the two pin maps. Directed runs then time the activity stretch and the first blink transitions in the combined mode.

// File: rtl/link_irq_pkg.sv
package link_irq_pkg;
  typedef enum logic [1:0] {
    IRQ_IDLE = 2'd0,
    IRQ_ON   = 2'd1,
    IRQ_GAP  = 2'd2
  } irq_state_t;
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic ff1_q;
  logic ff2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff1_q <= 1'b0;
      ff2_q <= 1'b0;
    end else begin
      ff1_q <= 1'b1;
      ff2_q <= ff1_q;
    end
  end

  assign rst_sync_n = ff2_q;
endmodule

// File: rtl/link_irq_fsm.sv
module link_irq_fsm
  import link_irq_pkg::*;
#(
  parameter int GAP_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  input  logic ack_wr,
  output logic irq_active
);
  localparam int GW = $clog2(GAP_CYCLES + 1);

  irq_state_t    state_q, state_d;
  logic          link_q;
  logic          pend_q, pend_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          chg;

  assign chg = link_up ^ link_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    gap_d   = gap_q;
    unique case (state_q)
      IRQ_IDLE: begin
        if (chg) state_d = IRQ_ON;
      end
      IRQ_ON: begin
        if (ack_wr) begin
          if (pend_q || chg) begin
            state_d = IRQ_GAP;
            gap_d   = GW'(GAP_CYCLES - 1);
          end else begin
            state_d = IRQ_IDLE;
          end
          pend_d = 1'b0;
        end else if (chg) begin
          pend_d = 1'b1;
        end
      end
      IRQ_GAP: begin
        // changes in the gap merge into the coming reassertion
        if (gap_q == '0) state_d = IRQ_ON;
        else             gap_d   = gap_q - 1'b1;
      end
      default: state_d = IRQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= IRQ_IDLE;
      link_q  <= 1'b0;
      pend_q  <= 1'b0;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      link_q  <= link_up;
      pend_q  <= pend_d;
      gap_q   <= gap_d;
    end
  end

  assign irq_active = (state_q == IRQ_ON);

  p_raise_on_change_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == IRQ_IDLE && chg) |=> irq_active);
  p_hold_until_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_active && !ack_wr) |=> irq_active);
  p_idle_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == IRQ_IDLE && !chg) |=> !irq_active);
  p_gap_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == IRQ_GAP) |-> (gap_q < GW'(GAP_CYCLES)));
  p_gap_reassert_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == IRQ_GAP && gap_q == '0) |=> irq_active);
  p_single_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (state_q == IRQ_ON));
endmodule

// File: rtl/act_led_gen.sv
module act_led_gen #(
  parameter int ACT_HOLD  = 2500000,
  parameter int BLINK_DIV = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_pulse,
  output logic act_on,
  output logic blink
);
  localparam int AW = $clog2(ACT_HOLD + 1);
  localparam int DW = $clog2(BLINK_DIV + 1);

  logic [AW-1:0] hold_q, hold_d;
  logic [DW-1:0] div_q, div_d;
  logic          blink_q, blink_d;

  assign act_on = (hold_q != '0);

  always_comb begin
    hold_d = hold_q;
    if (act_pulse)      hold_d = AW'(ACT_HOLD);
    else if (act_on)    hold_d = hold_q - 1'b1;

    div_d   = div_q;
    blink_d = blink_q;
    if (!act_on) begin
      div_d   = '0;
      blink_d = 1'b0;
    end else if (div_q == DW'(BLINK_DIV - 1)) begin
      div_d   = '0;
      blink_d = ~blink_q;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      div_q   <= '0;
      blink_q <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      div_q   <= div_d;
      blink_q <= blink_d;
    end
  end

  assign blink = blink_q;

  p_stretch_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    act_pulse |=> act_on);
  p_blink_rest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !act_on |=> !blink);
endmodule

// File: rtl/irq_pin_mux.sv
module irq_pin_mux (
  input  logic pin_cfg,
  input  logic irq_level,
  input  logic act_on,
  input  logic coll,
  input  logic link_up,
  input  logic blink,
  output logic pin_act_n,
  output logic pin_col_n,
  output logic link_led_n
);
  always_comb begin
    if (pin_cfg) begin
      pin_act_n  = ~act_on;
      pin_col_n  = irq_level;
      link_led_n = ~link_up;
    end else begin
      pin_act_n  = irq_level;
      pin_col_n  = ~coll;
      if (!link_up)    link_led_n = 1'b1;
      else if (act_on) link_led_n = blink;
      else             link_led_n = 1'b0;
    end
  end
endmodule

// File: rtl/link_irq_ctrl.sv
module link_irq_ctrl #(
  parameter int GAP_CYCLES = 3,
  parameter int ACT_HOLD   = 2500000,
  parameter int BLINK_DIV  = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  input  logic act_pulse,
  input  logic coll,
  input  logic ack_wr,
  input  logic irq_invert,
  input  logic pin_cfg,
  output logic pin_act_n,
  output logic pin_col_n,
  output logic link_led_n
);
  logic rst_int_n;
  logic irq_active;
  logic irq_level;
  logic act_on;
  logic blink;

  rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_int_n)
  );

  link_irq_fsm #(.GAP_CYCLES(GAP_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .link_up   (link_up),
    .ack_wr    (ack_wr),
    .irq_active(irq_active)
  );

  act_led_gen #(.ACT_HOLD(ACT_HOLD), .BLINK_DIV(BLINK_DIV)) u_act (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .act_pulse(act_pulse),
    .act_on   (act_on),
    .blink    (blink)
  );

  assign irq_level = irq_invert ? irq_active : ~irq_active;

  irq_pin_mux u_mux (
    .pin_cfg   (pin_cfg),
    .irq_level (irq_level),
    .act_on    (act_on),
    .coll      (coll),
    .link_up   (link_up),
    .blink     (blink),
    .pin_act_n (pin_act_n),
    .pin_col_n (pin_col_n),
    .link_led_n(link_led_n)
  );

  p_irq_on_col_pin_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pin_cfg && irq_active) |-> (pin_col_n == irq_invert));
  p_irq_on_act_pin_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!pin_cfg && irq_active) |-> (pin_act_n == irq_invert));
  p_led_dark_no_link_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !link_up |-> link_led_n);
endmodule

// File: tb/tb_link_irq_ctrl.sv
`timescale 1ns/1ps
module tb_link_irq_ctrl;
  localparam int GAP  = 3;
  localparam int HOLD = 16;
  localparam int DIV  = 4;

  logic clk = 1'b0;
  logic rst_n, link_up, act_pulse, coll, ack_wr, irq_invert, pin_cfg;
  logic pin_act_n, pin_col_n, link_led_n;
  int   checks = 0;
  int   errors = 0;

  always #2.5 clk = ~clk;

  link_irq_ctrl #(.GAP_CYCLES(GAP), .ACT_HOLD(HOLD), .BLINK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .act_pulse(act_pulse),
    .coll(coll), .ack_wr(ack_wr), .irq_invert(irq_invert), .pin_cfg(pin_cfg),
    .pin_act_n(pin_act_n), .pin_col_n(pin_col_n), .link_led_n(link_led_n)
  );

  // {cfg, inv, coll, exp_act_n, exp_col_n, exp_led_n}, link down, no irq
  localparam logic [5:0] VEC [6] = '{
    6'b000_111, 6'b001_101, 6'b010_011,
    6'b100_111, 6'b101_111, 6'b111_101
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic set_link(input logic v);
    link_up = v;
    step();
  endtask

  task automatic ack();
    ack_wr = 1'b1;
    step();
    ack_wr = 1'b0;
  endtask

  task automatic act();
    act_pulse = 1'b1;
    step();
    act_pulse = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; link_up = 1'b0; act_pulse = 1'b0; coll = 1'b0;
    ack_wr = 1'b0; irq_invert = 1'b0; pin_cfg = 1'b1;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R10 reset state
    chk(pin_act_n, 1'b1, "R10 act pin");
    chk(pin_col_n, 1'b1, "R10 col pin");
    chk(link_led_n, 1'b1, "R10 link led");

    // R6 R7 R5 routing table with link down
    for (int i = 0; i < 6; i++) begin
      pin_cfg = VEC[i][5]; irq_invert = VEC[i][4]; coll = VEC[i][3];
      step();
      chk(pin_act_n, VEC[i][2], "R7/R6 table act pin");
      chk(pin_col_n, VEC[i][1], "R7/R6 table col pin");
      chk(link_led_n, VEC[i][0], "R6 table link led");
    end
    pin_cfg = 1'b1; irq_invert = 1'b0; coll = 1'b0;
    step();

    // R1 link up raises, R2 held
    set_link(1'b1);
    chk(pin_col_n, 1'b0, "R1 link up raises irq");
    chk(link_led_n, 1'b0, "R6 link led on");
    for (int k = 0; k < 5; k++) begin
      step();
      chk(pin_col_n, 1'b0, "R2 held before ack");
    end
    ack();
    chk(pin_col_n, 1'b1, "R2 ack lowers irq");
    for (int k = 0; k < 4; k++) begin
      step();
      chk(pin_col_n, 1'b1, "R2 stays low after ack");
    end
    ack();
    chk(pin_col_n, 1'b1, "R2 ack in idle ignored");
    step();
    chk(pin_col_n, 1'b1, "R2 ack in idle ignored later");

    // R1 link down raises; R3 R4 burst of changes
    set_link(1'b0);
    chk(pin_col_n, 1'b0, "R1 link down raises irq");
    set_link(1'b1);
    set_link(1'b0);
    chk(pin_col_n, 1'b0, "R4 still raised during burst");
    ack();
    for (int k = 0; k < GAP; k++) begin
      chk(pin_col_n, 1'b1, "R3 gap low");
      if (k < GAP - 1) step();
    end
    step();
    chk(pin_col_n, 1'b0, "R3 reassert after gap");
    ack();
    chk(pin_col_n, 1'b1, "R4 single queued event");
    for (int k = 0; k < 5; k++) begin
      step();
      chk(pin_col_n, 1'b1, "R4 no second reassert");
    end

    // R4 change during gap merged
    set_link(1'b1);
    set_link(1'b0);
    ack();
    chk(pin_col_n, 1'b1, "R3 gap start");
    set_link(1'b1);
    step();
    step();
    chk(pin_col_n, 1'b0, "R4 gap change merged reassert");
    ack();
    for (int k = 0; k < 5; k++) begin
      chk(pin_col_n, 1'b1, "R4 gap change not queued");
      step();
    end

    // R9 activity stretch on own pin (cfg 1)
    act();
    chk(pin_act_n, 1'b0, "R9 activity on");
    for (int k = 1; k < HOLD; k++) step();
    chk(pin_act_n, 1'b0, "R9 activity last cycle");
    step();
    chk(pin_act_n, 1'b1, "R9 activity ends");

    // R5 inverted polarity
    irq_invert = 1'b1;
    step();
    chk(pin_col_n, 1'b0, "R5 inverted idle level");
    set_link(1'b0);
    chk(pin_col_n, 1'b1, "R5 inverted raised level");
    ack();
    chk(pin_col_n, 1'b0, "R5 inverted after ack");
    irq_invert = 1'b0;

    // R7 R8 combined mode
    pin_cfg = 1'b0;
    step();
    chk(link_led_n, 1'b1, "R8 no link led high");
    set_link(1'b1);
    chk(pin_act_n, 1'b0, "R7 irq on act pin");
    chk(link_led_n, 1'b0, "R8 link no activity low");
    coll = 1'b1;
    step();
    chk(pin_col_n, 1'b0, "R7 collision shown");
    coll = 1'b0;
    ack();
    chk(pin_act_n, 1'b1, "R7 irq cleared on act pin");
    chk(pin_col_n, 1'b1, "R7 collision cleared");
    act();
    chk(link_led_n, 1'b0, "R8 blink first phase");
    for (int k = 1; k <= 8; k++) begin
      step();
      if (k < DIV)       chk(link_led_n, 1'b0, "R8 blink low phase");
      else if (k == DIV) chk(link_led_n, 1'b1, "R8 blink toggles high");
      else if (k == 2*DIV) chk(link_led_n, 1'b0, "R8 blink toggles low");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule